// File: doc/BRIEF.md
# Hardware Error Recovery Sequencer

This block is the control state machine that takes a core through a fixed recovery procedure once an error has been detected. A one-cycle detect pulse makes it stop instruction processing at once. It then asks the store queue to empty into the second-level cache and waits for that to finish. Next it holds the functional units in reset for a fixed number of cycles. Finally it reads one protected register word and checks it with a single-error-correct, double-error-detect Hamming code.

A clean word ends the procedure. Processing resumes and a recovery counter steps by one. A word with one flipped bit is corrected and written back to the register file. The check then runs exactly one more time. If that second check is still not clean, or if any check finds two flipped bits, the block stops for good. In that state it keeps processing halted and raises a fatal flag until the next reset.

Top module: `err_recovery_seq`

## Requirements
- R1: After reset, halt, drain_req, unit_rst, rf_rd_en, rf_wr_en and fatal_error are low and recover_count is zero.
- R2: A fault_pulse seen while the block is idle raises halt in that same cycle. halt then stays high through every recovery step and drops only in the resume cycle, or never if the sequence fails. drain_req rises two cycles after the pulse.
- R3: drain_req stays high until a cycle in which drain_done is high. drain_done has no effect while drain_req is low.
- R4: unit_rst is high for exactly RST_CYCLES consecutive cycles (default 4), starting in the cycle after the drain completes.
- R5: Codeword layout for DATA_W=32 is 39 bits. Bit 0 is an overall parity over bits 1 to 38, chosen so that all 39 bits XOR to zero. Bits 1, 2, 4, 8, 16 and 32 are check bits; check bit 2^k makes the XOR of all bits whose index has bit k set equal to zero. The data bits fill the remaining indices in ascending order, data bit 0 at index 3.
- R6: A check that finds a clean word leads to one resume cycle with halt low. recover_count then shows one more from the following cycle, and the block returns to idle.
- R7: A first check that finds exactly one flipped bit (any index, including bit 0) is followed by one cycle with rf_wr_en high. In that cycle rf_wr_word is the fully corrected codeword. A second read (rf_rd_en) follows in the very next cycle.
- R8: Two flipped bits at either check, or any flipped bit at the second check, lead to a stop state. In that state fatal_error and halt stay high and recover_count does not change until reset.
- R9: fault_pulse is ignored while a recovery is in progress, in the resume cycle and in the stop state.
- R10: rf_rd_en is high for exactly one cycle per check. At most one of drain_req, unit_rst, rf_rd_en, rf_wr_en is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_pulse | input | 1 | Error detected, sampled only while idle |
| halt | output | 1 | Stop instruction processing |
| drain_req | output | 1 | Request to empty the store queue into the second-level cache |
| drain_done | input | 1 | Store queue has been emptied |
| unit_rst | output | 1 | Reset to the functional units |
| rf_rd_en | output | 1 | Read strobe for the protected register |
| rf_rd_word | input | 39 | Protected register codeword, valid in the cycle of rf_rd_en |
| rf_wr_en | output | 1 | Write strobe for the corrected codeword |
| rf_wr_word | output | 39 | Corrected codeword |
| fatal_error | output | 1 | Recovery failed, block stopped |
| recover_count | output | 8 | Number of successful recoveries |

## Verification
Each state drives its own visible strobe, so a wrong state shows on halt, drain_req, unit_rst, rf_rd_en or rf_wr_en in the same cycle it is entered. A reset timer that is off by one shows as a unit_rst pulse of the wrong length and a shifted read strobe. A wrong syndrome or a misplaced data bit shows in the check cycle: the block takes the wrong path (write-back, resume or stop). It can also write a codeword that differs from the one the bench encoded itself. A counter that steps wrongly is seen one cycle after the resume cycle.

// File: rtl/ers_pkg.sv
// Shared types and code-size helpers for the error recovery sequencer.
// Assumes the Hamming layout: parity bit at index 0, check bits at powers of two.
package ers_pkg;

    // Recovery steps, in the order they are taken
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HALT,
        ST_DRAIN,
        ST_RESET,
        ST_CHECK1,
        ST_FIX,
        ST_CHECK2,
        ST_RESUME,
        ST_FAIL
    } rec_state_t;

    // Number of Hamming check bits needed for dw data bits
    function automatic int chk_bits(int dw);
        int r;
        r = 0;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // Full codeword width including the overall parity bit
    function automatic int code_bits(int dw);
        return dw + chk_bits(dw) + 1;
    endfunction

    // True when v is a nonzero power of two (a check-bit index)
    function automatic bit is_pow2(int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/ers_secded_enc.sv
// SECDED encoder: places data bits at the non-power-of-two indices, fills each
// check bit so its covered group has even parity, then sets overall parity.
// Assumes CODE_W and CHK_W come from the package helpers for DATA_W.
module ers_secded_enc #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = ers_pkg::chk_bits(DATA_W),
    parameter int CODE_W = ers_pkg::code_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);

    // Build the codeword in one combinational pass
    always_comb begin
        logic [CODE_W-1:0] w;
        logic              p;
        int                j;
        w = '0;
        j = 0;
        for (int i = 1; i < CODE_W; i++) begin
            if (!ers_pkg::is_pow2(i)) begin
                w[i] = data[j];
                j++;
            end
        end
        for (int k = 0; k < CHK_W; k++) begin
            p = 1'b0;
            for (int i = 1; i < CODE_W; i++) begin
                if (!ers_pkg::is_pow2(i) && (((i >> k) & 1) != 0)) p = p ^ w[i];
            end
            w[1 << k] = p;
        end
        w[0] = ^w[CODE_W-1:1];
        code = w;
    end

endmodule

// File: rtl/ers_secded_dec.sv
// SECDED checker: forms the syndrome and overall parity of a codeword, flags a
// clean or single-bit case, and returns the data with any single flip undone.
// Anything neither clean nor single is treated as uncorrectable by the caller.
module ers_secded_dec #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = ers_pkg::chk_bits(DATA_W),
    parameter int CODE_W = ers_pkg::code_bits(DATA_W)
) (
    input  logic [CODE_W-1:0] word,
    output logic              clean,
    output logic              single,
    output logic [DATA_W-1:0] data
);

    logic [CHK_W-1:0] syn;
    logic             overall;

    // Syndrome is the XOR of the indices of all set bits
    always_comb begin
        syn = '0;
        for (int i = 1; i < CODE_W; i++) begin
            if (word[i]) syn = syn ^ CHK_W'(i);
        end
        overall = ^word;
    end

    // Classify the word from syndrome and overall parity
    always_comb begin
        clean  = (syn == '0) && !overall;
        single = overall && (int'(syn) < CODE_W);
    end

    // Extract data, flipping the bit the syndrome points at
    always_comb begin
        int j;
        j    = 0;
        data = '0;
        for (int i = 1; i < CODE_W; i++) begin
            if (!ers_pkg::is_pow2(i)) begin
                data[j] = word[i] ^ (overall && (int'(syn) == i));
                j++;
            end
        end
    end

endmodule

// File: rtl/ers_ctrl.sv
// Recovery state machine: stop, drain, unit reset, check, optional fix and
// recheck, then resume or stop for good. Assumes the codeword check results
// are valid in the same cycle the read strobe is high.
module ers_ctrl #(
    parameter int RST_CYCLES = 4,
    parameter int CNT_W      = 8,
    parameter int CODE_W     = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic              drain_done,
    input  logic              chk_clean,
    input  logic              chk_single,
    input  logic [CODE_W-1:0] fix_word,
    output logic              halt,
    output logic              drain_req,
    output logic              unit_rst,
    output logic              rd_en,
    output logic              wr_en,
    output logic [CODE_W-1:0] wr_word,
    output logic              fatal,
    output logic [CNT_W-1:0]  rcount
);
    import ers_pkg::*;

    localparam int TW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);

    rec_state_t      state, nxt;
    logic [TW-1:0]   tmr;

    // Next-step selection
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (fault) nxt = ST_HALT;
            ST_HALT:   nxt = ST_DRAIN;
            ST_DRAIN:  if (drain_done) nxt = ST_RESET;
            ST_RESET:  if (tmr == TW'(RST_CYCLES - 1)) nxt = ST_CHECK1;
            ST_CHECK1: nxt = chk_clean ? ST_RESUME : (chk_single ? ST_FIX : ST_FAIL);
            ST_FIX:    nxt = ST_CHECK2;
            ST_CHECK2: nxt = chk_clean ? ST_RESUME : ST_FAIL;
            ST_RESUME: nxt = ST_IDLE;
            ST_FAIL:   nxt = ST_FAIL;
            default:   nxt = ST_FAIL;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Unit reset length timer, cleared outside the reset step
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_RESET) tmr <= '0;
        else                             tmr <= tmr + 1'b1;
    end

    // Capture the corrected codeword during the first check
    always_ff @(posedge clk) begin
        if (!rst_n)                                wr_word <= '0;
        else if (state == ST_CHECK1 && chk_single) wr_word <= fix_word;
    end

    // Count completed recoveries
    always_ff @(posedge clk) begin
        if (!rst_n)                 rcount <= '0;
        else if (state == ST_RESUME) rcount <= rcount + 1'b1;
    end

    // Strobes decoded from the current step
    always_comb begin
        halt      = ((state == ST_IDLE) && fault) ||
                    ((state != ST_IDLE) && (state != ST_RESUME));
        drain_req = (state == ST_DRAIN);
        unit_rst  = (state == ST_RESET);
        rd_en     = (state == ST_CHECK1) || (state == ST_CHECK2);
        wr_en     = (state == ST_FIX);
        fatal     = (state == ST_FAIL);
    end

endmodule

// File: rtl/err_recovery_seq.sv
// Top of the error recovery sequencer: the control machine plus the SECDED
// checker on the register read path and the re-encoder for the write-back.
// Assumes the register file returns rf_rd_word combinationally.
module err_recovery_seq #(
    parameter  int DATA_W     = 32,
    parameter  int RST_CYCLES = 4,
    parameter  int CNT_W      = 8,
    localparam int CHK_W      = ers_pkg::chk_bits(DATA_W),
    localparam int CODE_W     = ers_pkg::code_bits(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_pulse,
    output logic              halt,
    output logic              drain_req,
    input  logic              drain_done,
    output logic              unit_rst,
    output logic              rf_rd_en,
    input  logic [CODE_W-1:0] rf_rd_word,
    output logic              rf_wr_en,
    output logic [CODE_W-1:0] rf_wr_word,
    output logic              fatal_error,
    output logic [CNT_W-1:0]  recover_count
);

    logic              chk_clean, chk_single;
    logic [DATA_W-1:0] fixed_data;
    logic [CODE_W-1:0] fix_word;

    ers_secded_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_dec (
        .word   (rf_rd_word),
        .clean  (chk_clean),
        .single (chk_single),
        .data   (fixed_data)
    );

    ers_secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CODE_W(CODE_W)) u_enc (
        .data (fixed_data),
        .code (fix_word)
    );

    ers_ctrl #(.RST_CYCLES(RST_CYCLES), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault      (fault_pulse),
        .drain_done (drain_done),
        .chk_clean  (chk_clean),
        .chk_single (chk_single),
        .fix_word   (fix_word),
        .halt       (halt),
        .drain_req  (drain_req),
        .unit_rst   (unit_rst),
        .rd_en      (rf_rd_en),
        .wr_en      (rf_wr_en),
        .wr_word    (rf_wr_word),
        .fatal      (fatal_error),
        .rcount     (recover_count)
    );

endmodule

// File: rtl/ers_sva.sv
// Property checker for the error recovery sequencer, bound to the top module.
// Assumes synchronous active-low reset; all properties are off during reset.
module ers_sva #(
    parameter int RST_CYCLES = 4,
    parameter int CNT_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt,
    input logic             drain_req,
    input logic             drain_done,
    input logic             unit_rst,
    input logic             rf_rd_en,
    input logic             rf_wr_en,
    input logic             fatal_error,
    input logic [CNT_W-1:0] recover_count
);

    int rst_len;

    // Length of the current run of unit_rst cycles
    always_ff @(posedge clk) begin
        if (!rst_n)        rst_len <= 0;
        else if (unit_rst) rst_len <= rst_len + 1;
        else               rst_len <= 0;
    end

    // R2
    halt_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req || unit_rst || rf_rd_en || rf_wr_en || fatal_error) |-> halt);

    // R3
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && !drain_done) |=> drain_req);

    // R4
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unit_rst) |-> (rst_len == RST_CYCLES));

    // R7
    fix_recheck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> rf_rd_en);

    // R8
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_error |=> (fatal_error && $stable(recover_count)));

    // R10
    stage_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drain_req, unit_rst, rf_rd_en, rf_wr_en}));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(recover_count) |-> (recover_count == $past(recover_count) + CNT_W'(1)));

endmodule

bind err_recovery_seq ers_sva #(.RST_CYCLES(RST_CYCLES), .CNT_W(CNT_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt          (halt),
    .drain_req     (drain_req),
    .drain_done    (drain_done),
    .unit_rst      (unit_rst),
    .rf_rd_en      (rf_rd_en),
    .rf_wr_en      (rf_wr_en),
    .fatal_error   (fatal_error),
    .recover_count (recover_count)
);

// File: tb/err_recovery_seq_test.sv
module err_recovery_seq_test;

    localparam int CW  = 39;
    localparam int RSTC = 4;
    localparam int S_IDLE = 0, S_HALT = 1, S_DRAIN = 2, S_RESET = 3, S_CHK1 = 4,
                   S_FIX = 5, S_CHK2 = 6, S_RESUME = 7, S_FAIL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fault_pulse = 1'b0;
    logic          drain_done = 1'b0;
    logic [CW-1:0] rf_word = '0;
    logic          halt, drain_req, unit_rst, rf_rd_en, rf_wr_en, fatal_error;
    logic [CW-1:0] rf_wr_word;
    logic [7:0]    recover_count;

    int checks = 0, fails = 0;
    int m_state = S_IDLE, m_t = 0, m_cnt = 0;
    int rf_flips = 0;
    logic          rf_lock = 1'b0;
    logic [CW-1:0] good = '0;

    always #10 clk = ~clk;

    err_recovery_seq uut (
        .clk(clk), .rst_n(rst_n), .fault_pulse(fault_pulse), .halt(halt),
        .drain_req(drain_req), .drain_done(drain_done), .unit_rst(unit_rst),
        .rf_rd_en(rf_rd_en), .rf_rd_word(rf_word), .rf_wr_en(rf_wr_en),
        .rf_wr_word(rf_wr_word), .fatal_error(fatal_error),
        .recover_count(recover_count)
    );

    // Independent encoder: zero the total syndrome by setting check bits
    function automatic logic [CW-1:0] encode(input logic [31:0] d);
        logic [CW-1:0] w;
        int j, s;
        w = '0; j = 0; s = 0;
        for (int i = 1; i < CW; i++) begin
            if ((i & (i - 1)) != 0) begin
                w[i] = d[j];
                j++;
            end
        end
        for (int i = 1; i < CW; i++) if (w[i]) s = s ^ i;
        for (int k = 0; k < 6; k++) if (((s >> k) & 1) != 0) w[1 << k] = 1'b1;
        w[0] = ^w[CW-1:1];
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare outputs against the model, then advance one clock
    task automatic tick();
        bit we;
        logic [CW-1:0] wv;
        bit e_halt;
        #5;
        if (rst_n) begin
            e_halt = (m_state == S_IDLE && fault_pulse) ||
                     (m_state != S_IDLE && m_state != S_RESUME);
            chk(halt == e_halt, "R2", "halt", halt, e_halt);
            chk(drain_req == (m_state == S_DRAIN), "R3", "drain_req", drain_req, m_state == S_DRAIN);
            chk(unit_rst == (m_state == S_RESET), "R4", "unit_rst", unit_rst, m_state == S_RESET);
            chk(rf_rd_en == (m_state == S_CHK1 || m_state == S_CHK2), "R10", "rf_rd_en",
                rf_rd_en, m_state == S_CHK1 || m_state == S_CHK2);
            chk(rf_wr_en == (m_state == S_FIX), "R7", "rf_wr_en", rf_wr_en, m_state == S_FIX);
            chk(fatal_error == (m_state == S_FAIL), "R8", "fatal_error", fatal_error, m_state == S_FAIL);
            chk(int'(recover_count) == m_cnt, "R6", "recover_count", recover_count, m_cnt);
            if (m_state == S_FIX) chk(rf_wr_word == good, "R5", "rf_wr_word", rf_wr_word, good);
        end
        we = rf_wr_en;
        wv = rf_wr_word;
        @(posedge clk);
        if (!rst_n) begin
            m_state = S_IDLE; m_t = 0; m_cnt = 0;
        end else begin
            case (m_state)
                S_IDLE:   if (fault_pulse) m_state = S_HALT;
                S_HALT:   m_state = S_DRAIN;
                S_DRAIN:  if (drain_done) begin m_state = S_RESET; m_t = 0; end
                S_RESET:  begin m_t++; if (m_t == RSTC) m_state = S_CHK1; end
                S_CHK1:   m_state = (rf_flips == 0) ? S_RESUME : (rf_flips == 1 ? S_FIX : S_FAIL);
                S_FIX:    m_state = S_CHK2;
                S_CHK2:   m_state = (rf_flips == 0) ? S_RESUME : S_FAIL;
                S_RESUME: begin m_cnt++; m_state = S_IDLE; end
                default:  m_state = S_FAIL;
            endcase
        end
        if (we && !rf_lock) begin
            rf_word = wv;
            rf_flips = (wv == good) ? 0 : 2;
        end
        #5;
    endtask

    task automatic load(input logic [31:0] d, input int fa, input int fb);
        good = encode(d);
        rf_word = good;
        rf_flips = 0;
        if (fa >= 0) begin rf_word[fa] = ~rf_word[fa]; rf_flips++; end
        if (fb >= 0) begin rf_word[fb] = ~rf_word[fb]; rf_flips++; end
    endtask

    // One recovery: pulse, optional drain delay with stray pulses, then settle
    task automatic recover(input int drain_wait, input bit stray);
        fault_pulse = 1'b1; tick(); fault_pulse = 1'b0;
        tick();
        for (int n = 0; n < drain_wait; n++) begin
            fault_pulse = stray; tick(); fault_pulse = 1'b0;
        end
        drain_done = 1'b1; tick(); drain_done = 1'b0;
        for (int n = 0; n < RSTC + 6; n++) begin
            fault_pulse = stray && (n == 2); tick(); fault_pulse = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rf_lock = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(posedge clk); #5;
        do_reset();
        // R1: reset state
        #5;
        chk(!halt && !drain_req && !unit_rst && !rf_rd_en && !rf_wr_en && !fatal_error,
            "R1", "strobes after reset", {halt, drain_req, unit_rst, rf_rd_en, rf_wr_en, fatal_error}, 0);
        chk(recover_count == 0, "R1", "count after reset", recover_count, 0);
        #15;
        // clean word, slow drain
        load(32'hDEADBEEF, -1, -1);
        recover(3, 1'b0);
        chk(int'(recover_count) == 1, "R6", "clean recovery count", recover_count, 1);
        // R3: drain_done held high while idle is ignored
        drain_done = 1'b1; tick(); tick(); drain_done = 1'b0;
        // single flip in a data bit, stray faults during recovery (R9)
        load(32'h12345678, 13, -1);
        recover(2, 1'b1);
        chk(int'(recover_count) == 2, "R9", "stray pulses ignored", recover_count, 2);
        // single flip in a check bit and in the parity bit (R7)
        load(32'hA5A5F00F, 8, -1);
        recover(0, 1'b0);
        load(32'h0000_0001, 0, -1);
        recover(1, 1'b0);
        chk(int'(recover_count) == 4, "R7", "fixed recoveries", recover_count, 4);
        // highest index is a data bit
        load(32'h8000_0000, 38, -1);
        recover(0, 1'b0);
        chk(rf_word == good, "R5", "register after write-back", rf_word, good);
        // double flip: stop, pulses ignored, sticky (R8)
        load(32'hCAFEF00D, 5, 30);
        recover(1, 1'b1);
        for (int n = 0; n < 4; n++) begin fault_pulse = n[0]; tick(); end
        fault_pulse = 1'b0;
        chk(fatal_error && halt, "R8", "stop after double flip", {fatal_error, halt}, 3);
        do_reset();
        tick();
        // writes blocked: second check still single, stop (R8)
        load(32'h0F0F0F0F, 21, -1);
        rf_lock = 1'b1;
        recover(0, 1'b0);
        chk(fatal_error == 1'b1, "R8", "stop after failed recheck", fatal_error, 1);
        do_reset();
        load(32'hFFFFFFFF, -1, -1);
        recover(0, 1'b0);
        chk(int'(recover_count) == 1, "R6", "count after second reset", recover_count, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule